// File: doc/BRIEF.md
# Cartridge Program-ROM Banking Controller with Power-Up Lockout

This block sits between an 8-bit CPU bus and a program ROM on a game cartridge. It watches CPU writes into the upper half of the address space. A write into one window loads a 4-bit inner bank number. A write into the other window loads a 3-bit outer bank number. The inner bank and CPU address line A14 drive the high ROM address lines. The lower 16 KiB CPU window shows the selected inner bank. The upper 16 KiB window always shows the last inner bank (all ones). The outer bank is brought out on its own pins for the board to use.

The block also drives the ROM output-enable and chip-enable strobes. A lockout state machine holds the ROM chip-enable inactive from power-up. While the ROM is locked out, the block raises a read-override output that forces the value $EA onto every CPU read. The lockout machine has three states:
- `LK_LOCKED` is the power-up state.
- The transition *arm* leads from `LK_LOCKED` to `LK_ARMED`. It is taken when the lockout input is low.
- The transition *unlock* leads from `LK_ARMED` to `LK_OPEN`. It is taken on a CPU read that starts in page $F000-$FFFF.
- `LK_OPEN` holds until power-up reset.

All registers update on the rising system clock. The ROM-select strobe is sampled there, and only the clock in which it goes low counts as a bus access.

Top module: `cart_prg_mapper`

## Requirements
- R1: A CPU write (rw low) that starts while cpu_addr_hi[2] (A14) is 1, i.e. $C000-$FFFF, loads cpu_data[3:0] into the inner bank. cpu_data[7:4] are ignored.
- R2: A CPU write that starts while A14 is 0, i.e. $8000-$BFFF, loads the outer bank from the data bits as follows: outer_bank[0] = cpu_data[2], outer_bank[1] = cpu_data[3], outer_bank[2] = cpu_data[4]. Bits 7, 6, 5, 1 and 0 are ignored.
- R3: Each low period of rom_sel_n is one access, however long it lasts. Only data present in the first clock of the low period can be written.
- R4: rom_addr_hi equals the inner bank when A14 is 0, and 4'b1111 when A14 is 1.
- R5: rom_oe_n is low exactly when rom_sel_n is low and cpu_rw is high.
- R6: rom_ce_n is high in `LK_LOCKED` and `LK_ARMED`, and low in `LK_OPEN`.
- R7: After rst_n is released, the machine is in `LK_LOCKED` and both bank registers are zero.
- R8: While the ROM is locked out, rd_override_en is high on every CPU read (cpu_rw high) at any address, and rd_override_data is 8'hEA. In `LK_OPEN`, rd_override_en stays low.
- R9: A read from $F000-$FFFF made before lock_n has been seen low leaves the block locked.
- R10: A read starting in $F000-$FFFF (cpu_addr_hi == 4'hF) after the arm transition unlocks the ROM from the next clock on. A read in $E000-$EFFF does not unlock it. Once open, the block stays open even if lock_n goes low again.
- R11: pwr_ctl is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| cpu_addr_hi | input | 4 | CPU address lines A15..A12 |
| cpu_data | input | 8 | CPU data bus |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| rom_sel_n | input | 1 | Active-low ROM-select strobe for $8000-$FFFF |
| lock_n | input | 1 | Active-low reset/lockout input that arms the unlock |
| rom_addr_hi | output | 4 | ROM address lines A17..A14 |
| outer_bank | output | 3 | Outer bank number |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rd_override_en | output | 1 | Forces rd_override_data onto CPU reads |
| rd_override_data | output | 8 | Value forced while locked out |
| pwr_ctl | output | 1 | Power-switch control, held low |

## Verification
The assertions check the following on every cycle:
- The lockout machine never goes from `LK_LOCKED` straight to `LK_OPEN`, and never leaves `LK_OPEN`.
- The chip enable only falls after a read in the top page.
- Each strobe low period produces at most one write event, and the bank registers only change on such an event.
- While locked out, every read carries the $EA override.
- The upper window always maps to the last bank.
- The power control stays low.

Only the bench scenarios can show the data-bit routing into each register and which data bits are ignored. They also show that data changed in the middle of a held strobe is dropped, and they cover the full reset, arm and read ordering that the unlock needs.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_ARMED  = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_t;

    localparam int ADDR_HI_W = 4;
    localparam int DATA_W    = 8;
endpackage

// File: rtl/cpm_bus_strobe.sv
// Turns the ROM-select strobe into one-clock write and read access events.
module cpm_bus_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic rom_sel_n,
    input  logic cpu_rw,
    output logic wr_evt,
    output logic rd_evt
);
    logic sel_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_n_q <= 1'b1;
        else        sel_n_q <= rom_sel_n;
    end

    // An access starts in the clock where the strobe is first seen low.
    logic start;
    assign start  = sel_n_q & ~rom_sel_n;
    assign wr_evt = start & ~cpu_rw;
    assign rd_evt = start & cpu_rw;

    // R3: a held strobe never yields back-to-back write events
    p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt);
endmodule

// File: rtl/cpm_bank_regs.sv
// Inner and outer bank registers, each loaded from its own write window.
module cpm_bank_regs #(
    parameter int INNER_W   = 4,
    parameter int OUTER_W   = 3,
    parameter int OUTER_LSB = 2,
    localparam int DIN_W    = (INNER_W > OUTER_LSB + OUTER_W) ? INNER_W : OUTER_LSB + OUTER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_evt,
    input  logic               hi_window,
    input  logic [DIN_W-1:0]   din,
    output logic [INNER_W-1:0] inner_q,
    output logic [OUTER_W-1:0] outer_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inner_q <= '0;
            outer_q <= '0;
        end else if (wr_evt) begin
            if (hi_window) inner_q <= din[INNER_W-1:0];
            else           outer_q <= din[OUTER_LSB +: OUTER_W];
        end
    end

    // R3: bank contents change only on a write event
    p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_evt |=> ($stable(inner_q) && $stable(outer_q)));
endmodule

// File: rtl/cpm_lock_fsm.sv
// Power-up lockout: locked -> armed (lockout input low) -> open (top-page read).
module cpm_lock_fsm
    import cpm_pkg::*;
#(
    parameter logic [ADDR_HI_W-1:0] UNLOCK_PAGE = 4'hF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_n,
    input  logic                 rd_evt,
    input  logic [ADDR_HI_W-1:0] addr_hi,
    output logic                 protect,
    output lock_state_t          state
);
    lock_state_t state_nx;
    logic        top_page_rd;

    assign top_page_rd = rd_evt && (addr_hi == UNLOCK_PAGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        protect  = 1'b1;
        unique case (state)
            LK_LOCKED: if (!lock_n)     state_nx = LK_ARMED;
            LK_ARMED:  if (top_page_rd) state_nx = LK_OPEN;
            LK_OPEN: begin
                protect = 1'b0;
            end
            default: state_nx = LK_LOCKED;
        endcase
    end

    // R9: no shortcut from locked straight to open
    p_no_skip_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_LOCKED) |=> (state != LK_OPEN));
    // R10: open is sticky until reset
    p_open_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_OPEN) |=> (state == LK_OPEN));
endmodule

// File: rtl/cpm_out_decode.sv
// Drives the ROM address lines, ROM strobes and the read override.
module cpm_out_decode #(
    parameter int          INNER_W  = 4,
    parameter logic [7:0]  LOCK_VAL = 8'hEA
) (
    input  logic               hi_window,
    input  logic [INNER_W-1:0] inner_q,
    input  logic               rom_sel_n,
    input  logic               cpu_rw,
    input  logic               protect,
    output logic [INNER_W-1:0] rom_addr_hi,
    output logic               rom_oe_n,
    output logic               rom_ce_n,
    output logic               ovr_en,
    output logic [7:0]         ovr_data,
    output logic               pwr_ctl
);
    localparam logic [INNER_W-1:0] LAST_BANK = '1;

    always_comb begin
        rom_addr_hi = hi_window ? LAST_BANK : inner_q;
        rom_oe_n    = rom_sel_n | ~cpu_rw;
        rom_ce_n    = protect;
        ovr_en      = protect & cpu_rw;
        ovr_data    = LOCK_VAL;
        pwr_ctl     = 1'b0;
    end
endmodule

// File: rtl/cart_prg_mapper.sv
module cart_prg_mapper
    import cpm_pkg::*;
#(
    parameter int          INNER_W   = 4,
    parameter int          OUTER_W   = 3,
    parameter int          OUTER_LSB = 2,
    parameter logic [7:0]  LOCK_VAL  = 8'hEA
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         cpu_addr_hi,
    input  logic [7:0]         cpu_data,
    input  logic               cpu_rw,
    input  logic               rom_sel_n,
    input  logic               lock_n,
    output logic [INNER_W-1:0] rom_addr_hi,
    output logic [OUTER_W-1:0] outer_bank,
    output logic               rom_oe_n,
    output logic               rom_ce_n,
    output logic               rd_override_en,
    output logic [7:0]         rd_override_data,
    output logic               pwr_ctl
);
    localparam int DIN_W = (INNER_W > OUTER_LSB + OUTER_W) ? INNER_W : OUTER_LSB + OUTER_W;

    logic        wr_evt, rd_evt, protect, hi_window;
    logic [INNER_W-1:0] inner_q;
    lock_state_t lk_state;
    logic        unused_bits;

    assign hi_window   = cpu_addr_hi[2];
    assign unused_bits = ^cpu_data[7:DIN_W] ^ ^lk_state;

    cpm_bus_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .rom_sel_n(rom_sel_n), .cpu_rw(cpu_rw),
        .wr_evt(wr_evt), .rd_evt(rd_evt)
    );

    cpm_bank_regs #(.INNER_W(INNER_W), .OUTER_W(OUTER_W), .OUTER_LSB(OUTER_LSB)) u_banks (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .hi_window(hi_window),
        .din(cpu_data[DIN_W-1:0]), .inner_q(inner_q), .outer_q(outer_bank)
    );

    cpm_lock_fsm #(.UNLOCK_PAGE(4'hF)) u_lock (
        .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .rd_evt(rd_evt),
        .addr_hi(cpu_addr_hi), .protect(protect), .state(lk_state)
    );

    cpm_out_decode #(.INNER_W(INNER_W), .LOCK_VAL(LOCK_VAL)) u_dec (
        .hi_window(hi_window), .inner_q(inner_q), .rom_sel_n(rom_sel_n),
        .cpu_rw(cpu_rw), .protect(protect), .rom_addr_hi(rom_addr_hi),
        .rom_oe_n(rom_oe_n), .rom_ce_n(rom_ce_n), .ovr_en(rd_override_en),
        .ovr_data(rd_override_data), .pwr_ctl(pwr_ctl)
    );

    // R10: chip enable only falls after a read begun in the top page
    p_ce_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_ce_n) |-> $past(!rom_sel_n && cpu_rw && cpu_addr_hi == 4'hF));
    // R8: locked-out reads always carry the override value
    p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_ce_n && cpu_rw) |-> (rd_override_en && rd_override_data == LOCK_VAL));
    // R4: upper window is pinned to the last bank
    p_hi_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr_hi[2] |-> (rom_addr_hi == '1));
    // R11: power control never rises
    p_pwr_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ctl);
endmodule

// File: tb/sim_cart_prg_mapper.sv
module sim_cart_prg_mapper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cpu_addr_hi = 4'h0;
    logic [7:0] cpu_data = 8'h00;
    logic       cpu_rw = 1'b1;
    logic       rom_sel_n = 1'b1;
    logic       lock_n = 1'b1;
    logic [3:0] rom_addr_hi;
    logic [2:0] outer_bank;
    logic       rom_oe_n, rom_ce_n, rd_override_en, pwr_ctl;
    logic [7:0] rd_override_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cart_prg_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .rom_sel_n(rom_sel_n), .lock_n(lock_n),
        .rom_addr_hi(rom_addr_hi), .outer_bank(outer_bank), .rom_oe_n(rom_oe_n),
        .rom_ce_n(rom_ce_n), .rd_override_en(rd_override_en),
        .rd_override_data(rd_override_data), .pwr_ctl(pwr_ctl)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr_hi = a; cpu_data = d; cpu_rw = 1'b0; rom_sel_n = 1'b0;
        @(negedge clk);
        rom_sel_n = 1'b1; cpu_rw = 1'b1;
    endtask

    // Starts a read, checks strobes mid-cycle, then ends it after one clock.
    task automatic bus_read(logic [3:0] a, string req, logic exp_ovr);
        @(negedge clk);
        cpu_addr_hi = a; cpu_rw = 1'b1; rom_sel_n = a[3] ? 1'b0 : 1'b1;
        #3;
        chk(req, {7'd0, rd_override_en}, {7'd0, exp_ovr});
        if (exp_ovr) chk(req, rd_override_data, 8'hEA);
        @(negedge clk);
        rom_sel_n = 1'b1;
    endtask

    task automatic inner_at(string req, logic [3:0] exp);
        @(negedge clk);
        cpu_addr_hi = 4'h8; #3;
        chk(req, {4'd0, rom_addr_hi}, {4'd0, exp});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        chk("R7 ce", {7'd0, rom_ce_n}, 8'd1);
        chk("R7 outer", {5'd0, outer_bank}, 8'd0);
        inner_at("R7 inner", 4'h0);
        chk("R11 pwr", {7'd0, pwr_ctl}, 8'd0);
    endtask

    task automatic t_inner();
        bus_write(4'hC, 8'hF5);
        inner_at("R1 inner upper bits ignored", 4'h5);
        bus_write(4'hF, 8'h0A);
        inner_at("R1 inner", 4'hA);
        cpu_addr_hi = 4'hC; #1;
        chk("R4 upper window", {4'd0, rom_addr_hi}, 8'h0F);
    endtask

    task automatic t_outer();
        bus_write(4'h8, 8'hE3);
        #3 chk("R2 ignored bits", {5'd0, outer_bank}, 8'd0);
        bus_write(4'hA, 8'h04);
        #3 chk("R2 bit2", {5'd0, outer_bank}, 8'd1);
        bus_write(4'hB, 8'h08);
        #3 chk("R2 bit3", {5'd0, outer_bank}, 8'd2);
        bus_write(4'h9, 8'h10);
        #3 chk("R2 bit4", {5'd0, outer_bank}, 8'd4);
        inner_at("R2 inner untouched", 4'hA);
    endtask

    task automatic t_held_strobe();
        @(negedge clk);
        cpu_addr_hi = 4'hC; cpu_data = 8'h03; cpu_rw = 1'b0; rom_sel_n = 1'b0;
        @(negedge clk);
        cpu_data = 8'h09;
        repeat (2) @(negedge clk);
        rom_sel_n = 1'b1; cpu_rw = 1'b1;
        inner_at("R3 one write per strobe", 4'h3);
    endtask

    task automatic t_oe();
        @(negedge clk);
        cpu_addr_hi = 4'h8; cpu_rw = 1'b1; rom_sel_n = 1'b0; #3;
        chk("R5 read", {7'd0, rom_oe_n}, 8'd0);
        cpu_rw = 1'b0; #1;
        chk("R5 write", {7'd0, rom_oe_n}, 8'd1);
        rom_sel_n = 1'b1; cpu_rw = 1'b1; #1;
        chk("R5 no select", {7'd0, rom_oe_n}, 8'd1);
    endtask

    task automatic t_unlock();
        bus_read(4'hF, "R9 read before arm", 1'b1);
        bus_read(4'h2, "R8 low address read", 1'b1);
        #3 chk("R9 still locked", {7'd0, rom_ce_n}, 8'd1);
        @(negedge clk); lock_n = 1'b0;
        @(negedge clk); lock_n = 1'b1;
        #3 chk("R6 armed still locked", {7'd0, rom_ce_n}, 8'd1);
        bus_read(4'hE, "R10 wrong page", 1'b1);
        #3 chk("R10 wrong page stays locked", {7'd0, rom_ce_n}, 8'd1);
        bus_read(4'hF, "R10 unlock read", 1'b1);
        #3 chk("R6 open ce", {7'd0, rom_ce_n}, 8'd0);
        bus_read(4'h8, "R8 no override when open", 1'b0);
        @(negedge clk); lock_n = 1'b0;
        repeat (2) @(negedge clk);
        lock_n = 1'b1;
        #3 chk("R10 sticky", {7'd0, rom_ce_n}, 8'd0);
        chk("R11 pwr", {7'd0, pwr_ctl}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_inner();
        t_outer();
        t_held_strobe();
        t_oe();
        t_unlock();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule